// File: doc/BRIEF.md
# ADC Queue Freeze Controller

This block sits beside the sequencer of a queued analog-to-digital converter. It decides when that sequencer stops for a debug freeze request. A freeze request counts only while the configuration's freeze-enable bit is set. When no queue is running, the controller halts on the next edge. When a queue is running, it lets the conversion that is under way finish, and it halts before the next conversion starts. A change of the active queue's operating mode, or an abort of queue 2, cuts that wait short.

When the controller halts with a queue running, it stores the queue's command-word pointer, so the sequencer can continue from that entry later. It releases when the freeze line drops or when the enable bit is cleared. A hold output tells the sequencer not to start new work while a qualified request is present or the block is frozen.

Top module: `adc_freeze_ctrl`

## Requirements
- R1: After reset, frozen_o, hold_o and saved_vld_o are 0 and saved_ptr_o is 0.
- R2: While frz_en_i is 0 the freeze line has no effect: frozen_o stays 0 and hold_o stays 0.
- R3: A qualified request (frz_line_i=1 and frz_en_i=1) with q_active_i=0 sets frozen_o one clock later. It clears saved_vld_o and leaves saved_ptr_o unchanged.
- R4: A qualified request with q_active_i=1 and conv_busy_i=1 keeps frozen_o at 0 until a cycle with conv_done_i=1. frozen_o rises on the clock after that cycle. This includes a done pulse in the cycle of the request itself.
- R5: A qualified request with queue activity that sees mode_chg_i=1 or q2_abort_i=1 sets frozen_o one clock later, whether or not conv_done_i has arrived. This applies both in the request's first cycle and while waiting.
- R6: On every entry into the frozen state with q_active_i=1, saved_ptr_o takes the q_ptr_i value of the deciding cycle and saved_vld_o becomes 1. Both hold that value while frozen.
- R7: Dropping frz_line_i while frozen clears frozen_o one clock later. saved_vld_o and saved_ptr_o are kept so that the sequencer can resume from them.
- R8: Clearing frz_en_i while a freeze waits on a conversion cancels it: a later conv_done_i does not freeze the block.
- R9: Clearing frz_en_i while frozen clears frozen_o one clock later, even if frz_line_i stays 1.
- R10: hold_o is 1 exactly when a qualified request is present or frozen_o is 1. It is combinational on the request.
- R11: A qualified request with q_active_i=1 and conv_busy_i=0 sets frozen_o one clock later and captures the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_line_i | input | 1 | Debug freeze request line |
| frz_en_i | input | 1 | Configuration bit that lets the freeze line act |
| q_active_i | input | 1 | A queue is currently executing |
| conv_busy_i | input | 1 | A conversion is in progress |
| conv_done_i | input | 1 | One-cycle strobe at the end of a conversion |
| mode_chg_i | input | 1 | Active queue's operating mode was changed |
| q2_abort_i | input | 1 | Queue 2 was aborted |
| q_ptr_i | input | PTR_W | Current command-word pointer of the active queue |
| frozen_o | output | 1 | Registered frozen status |
| hold_o | output | 1 | Tells the sequencer to start no new conversion |
| saved_ptr_o | output | PTR_W | Pointer captured at freeze entry |
| saved_vld_o | output | 1 | A queue was active when the last freeze began |

## Verification
Two freeze paths can fire in the same cycle while the controller waits on a conversion: the end-of-conversion strobe and the immediate path for a mode change or abort. The bench drives both in one cycle and expects a single freeze entry on the next edge, with the pointer of that cycle. In a separate test it raises the request in the very cycle that the done strobe arrives, so that the wait is skipped. The register check then expects the frozen state and the new pointer on the next edge.

// File: rtl/adc_frz_pkg.sv
`timescale 1ns/1ps
package adc_frz_pkg;

  typedef enum logic [1:0] {
    FZ_RUN  = 2'd0,
    FZ_WAIT = 2'd1,
    FZ_HALT = 2'd2
  } fz_state_e;

  // Next state of the freeze controller.
  function automatic fz_state_e f_next_state(
    input fz_state_e cur,
    input logic      req_eff,
    input logic      q_active,
    input logic      busy,
    input logic      done,
    input logic      imm_evt
  );
    fz_state_e nxt;
    nxt = cur;
    unique case (cur)
      FZ_RUN: begin
        if (req_eff) begin
          if (!q_active || imm_evt || !busy || done) nxt = FZ_HALT;
          else                                       nxt = FZ_WAIT;
        end
      end
      FZ_WAIT: begin
        if (!req_eff)              nxt = FZ_RUN;
        else if (done || imm_evt)  nxt = FZ_HALT;
        else                       nxt = FZ_WAIT;
      end
      FZ_HALT: begin
        if (!req_eff) nxt = FZ_RUN;
      end
      default: nxt = FZ_RUN;
    endcase
    return nxt;
  endfunction

  // True on the transition into the halted state.
  function automatic logic f_entering(input fz_state_e cur, input fz_state_e nxt);
    return (nxt == FZ_HALT) && (cur != FZ_HALT);
  endfunction

endpackage

// File: rtl/adc_frz_qual.sv
`timescale 1ns/1ps
module adc_frz_qual (
  input  logic frz_line_i,
  input  logic frz_en_i,
  input  logic mode_chg_i,
  input  logic q2_abort_i,
  output logic req_eff_o,
  output logic imm_evt_o
);
  always_comb begin
    req_eff_o = frz_line_i & frz_en_i;
    imm_evt_o = mode_chg_i | q2_abort_i;
  end
endmodule

// File: rtl/adc_frz_fsm.sv
`timescale 1ns/1ps
module adc_frz_fsm
  import adc_frz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_eff_i,
  input  logic imm_evt_i,
  input  logic q_active_i,
  input  logic conv_busy_i,
  input  logic conv_done_i,
  output logic enter_frz_o,
  output logic in_wait_o,
  output logic frozen_o
);
  fz_state_e state_q, state_d;

  always_comb begin
    state_d     = f_next_state(state_q, req_eff_i, q_active_i,
                               conv_busy_i, conv_done_i, imm_evt_i);
    enter_frz_o = f_entering(state_q, state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FZ_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    in_wait_o = (state_q == FZ_WAIT);
    frozen_o  = (state_q == FZ_HALT);
  end
endmodule

// File: rtl/adc_frz_ptr_store.sv
`timescale 1ns/1ps
module adc_frz_ptr_store #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_frz_i,
  input  logic             q_active_i,
  input  logic [PTR_W-1:0] q_ptr_i,
  output logic [PTR_W-1:0] saved_ptr_o,
  output logic             saved_vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_ptr_o <= '0;
      saved_vld_o <= 1'b0;
    end else if (enter_frz_i) begin
      saved_vld_o <= q_active_i;
      if (q_active_i) saved_ptr_o <= q_ptr_i;
    end
  end
endmodule

// File: rtl/adc_freeze_ctrl.sv
`timescale 1ns/1ps
module adc_freeze_ctrl #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_line_i,
  input  logic             frz_en_i,
  input  logic             q_active_i,
  input  logic             conv_busy_i,
  input  logic             conv_done_i,
  input  logic             mode_chg_i,
  input  logic             q2_abort_i,
  input  logic [PTR_W-1:0] q_ptr_i,
  output logic             frozen_o,
  output logic             hold_o,
  output logic [PTR_W-1:0] saved_ptr_o,
  output logic             saved_vld_o
);
  // Named internal events, visible to the bound checker.
  logic req_eff;
  logic imm_evt;
  logic enter_frz;
  logic in_wait;

  adc_frz_qual u_qual (
    .frz_line_i (frz_line_i),
    .frz_en_i   (frz_en_i),
    .mode_chg_i (mode_chg_i),
    .q2_abort_i (q2_abort_i),
    .req_eff_o  (req_eff),
    .imm_evt_o  (imm_evt)
  );

  adc_frz_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_eff_i   (req_eff),
    .imm_evt_i   (imm_evt),
    .q_active_i  (q_active_i),
    .conv_busy_i (conv_busy_i),
    .conv_done_i (conv_done_i),
    .enter_frz_o (enter_frz),
    .in_wait_o   (in_wait),
    .frozen_o    (frozen_o)
  );

  adc_frz_ptr_store #(.PTR_W(PTR_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_frz_i (enter_frz),
    .q_active_i  (q_active_i),
    .q_ptr_i     (q_ptr_i),
    .saved_ptr_o (saved_ptr_o),
    .saved_vld_o (saved_vld_o)
  );

  always_comb hold_o = req_eff | frozen_o;
endmodule

// File: rtl/adc_freeze_chk.sv
`timescale 1ns/1ps
module adc_freeze_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frz_line_i,
  input logic             frz_en_i,
  input logic             q_active_i,
  input logic             conv_done_i,
  input logic [PTR_W-1:0] q_ptr_i,
  input logic             frozen_o,
  input logic             hold_o,
  input logic [PTR_W-1:0] saved_ptr_o,
  input logic             saved_vld_o,
  input logic             req_eff,
  input logic             imm_evt,
  input logic             enter_frz,
  input logic             in_wait
);
  // R2 / R9: with the enable low the block is never frozen on the next edge
  a_r2_disabled_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en_i |=> !frozen_o);

  // R3: an idle request freezes on the next edge without a valid pointer
  a_r3_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (req_eff && !frozen_o && !in_wait && !q_active_i) |=> (frozen_o && !saved_vld_o));

  // R4: while waiting, no done and no immediate event means no freeze yet
  a_r4_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && req_eff && !conv_done_i && !imm_evt) |=> !frozen_o);

  // R5: an immediate event with a qualified request freezes on the next edge
  a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_eff && imm_evt && !frozen_o) |=> frozen_o);

  // R6: pointer captured from the deciding cycle
  a_r6_ptr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_frz && q_active_i) |=> (saved_vld_o && saved_ptr_o == $past(q_ptr_i)));

  // R7: dropping the line releases the freeze on the next edge
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o && !frz_line_i) |=> !frozen_o);

  // R10: the sequencer is held whenever the block is frozen
  a_r10_hold_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |-> hold_o);
endmodule

bind adc_freeze_ctrl adc_freeze_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frz_line_i  (frz_line_i),
  .frz_en_i    (frz_en_i),
  .q_active_i  (q_active_i),
  .conv_done_i (conv_done_i),
  .q_ptr_i     (q_ptr_i),
  .frozen_o    (frozen_o),
  .hold_o      (hold_o),
  .saved_ptr_o (saved_ptr_o),
  .saved_vld_o (saved_vld_o),
  .req_eff     (req_eff),
  .imm_evt     (imm_evt),
  .enter_frz   (enter_frz),
  .in_wait     (in_wait)
);

// File: tb/test_adc_freeze_ctrl.sv
`timescale 1ns/1ps
module test_adc_freeze_ctrl;
  localparam int PTR_W = 6;
  localparam int NV    = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_line_i = 1'b0, frz_en_i = 1'b0, q_active_i = 1'b0;
  logic conv_busy_i = 1'b0, conv_done_i = 1'b0, mode_chg_i = 1'b0, q2_abort_i = 1'b0;
  logic [PTR_W-1:0] q_ptr_i = '0;
  logic frozen_o, hold_o, saved_vld_o;
  logic [PTR_W-1:0] saved_ptr_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_freeze_ctrl #(.PTR_W(PTR_W)) i_adc_freeze_ctrl (.*);

  // Fields: {line,en,qact,busy,done,mchg,abort}, ptr, {hold during, frozen after,
  // vld after}, saved ptr after, requirement number.
  localparam logic [25:0] VEC [NV] = '{
    {7'b1011000, 6'd0,  3'b000, 6'd0,  4'd2},  // R2 busy queue, enable low
    {7'b1000000, 6'd0,  3'b000, 6'd0,  4'd2},  // R2 idle, enable low
    {7'b1100000, 6'd0,  3'b110, 6'd0,  4'd3},  // R3 idle entry
    {7'b0100000, 6'd0,  3'b100, 6'd0,  4'd7},  // R7 release
    {7'b1111000, 6'd9,  3'b100, 6'd0,  4'd4},  // R4 wait starts
    {7'b1111000, 6'd9,  3'b100, 6'd0,  4'd4},  // R4 still waiting
    {7'b1111100, 6'd10, 3'b111, 6'd10, 4'd6},  // R6 done, capture 10
    {7'b1110000, 6'd11, 3'b111, 6'd10, 4'd6},  // R6 pointer held while frozen
    {7'b0100000, 6'd0,  3'b101, 6'd10, 4'd7},  // R7 release, pointer kept
    {7'b1111000, 6'd20, 3'b101, 6'd10, 4'd4},  // R4 wait
    {7'b1111010, 6'd21, 3'b111, 6'd21, 4'd5},  // R5 mode change while waiting
    {7'b1011000, 6'd0,  3'b101, 6'd21, 4'd9},  // R9 enable cleared while frozen
    {7'b1111000, 6'd30, 3'b101, 6'd21, 4'd4},  // R4 wait
    {7'b1011000, 6'd30, 3'b001, 6'd21, 4'd8},  // R8 enable cleared in wait
    {7'b1011100, 6'd30, 3'b001, 6'd21, 4'd8},  // R8 late done ignored
    {7'b1110000, 6'd33, 3'b111, 6'd33, 4'd11}, // R11 queue active, not busy
    {7'b0100000, 6'd0,  3'b101, 6'd33, 4'd7},  // R7
    {7'b1111001, 6'd40, 3'b111, 6'd40, 4'd5},  // R5 abort in first cycle
    {7'b0100000, 6'd0,  3'b101, 6'd40, 4'd7},  // R7
    {7'b1111100, 6'd41, 3'b111, 6'd41, 4'd4},  // R4 done in request cycle
    {7'b0100000, 6'd0,  3'b101, 6'd41, 4'd7},  // R7
    {7'b1111000, 6'd50, 3'b101, 6'd41, 4'd4},  // R4 wait
    {7'b1111101, 6'd51, 3'b111, 6'd51, 4'd5},  // R5 done and abort together
    {7'b0100000, 6'd0,  3'b101, 6'd51, 4'd7},  // R7
    {7'b1100000, 6'd7,  3'b110, 6'd51, 4'd3},  // R3 idle clears valid, keeps ptr
    {7'b0100000, 6'd0,  3'b100, 6'd51, 4'd7}   // R7
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] ctl, input logic [PTR_W-1:0] p);
    {frz_line_i, frz_en_i, q_active_i, conv_busy_i, conv_done_i, mode_chg_i, q2_abort_i} = ctl;
    q_ptr_i = p;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "frozen", frozen_o, 0);
    check("R1", "hold", hold_o, 0);
    check("R1", "saved_vld", saved_vld_o, 0);
    check("R1", "saved_ptr", saved_ptr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k][3:0]);
      drive(VEC[k][25:19], VEC[k][18:13]);
      #1;
      check("R10", $sformatf("hold v%0d", k), hold_o, VEC[k][12]);
      @(posedge clk);
      #1;
      check(tag, $sformatf("frozen v%0d", k), frozen_o, VEC[k][11]);
      check(tag, $sformatf("saved_vld v%0d", k), saved_vld_o, VEC[k][10]);
      check(tag, $sformatf("saved_ptr v%0d", k), saved_ptr_o, VEC[k][9:4]);
      @(negedge clk);
    end

    // R1: reset while frozen with a valid pointer
    drive(7'b1111100, 6'd17);
    @(negedge clk);
    check("R6", "frozen before reset", frozen_o, 1);
    check("R6", "ptr before reset", saved_ptr_o, 17);
    drive(7'b0000000, 6'd0);
    rst_n = 1'b0;
    #1;
    check("R1", "frozen in reset", frozen_o, 0);
    check("R1", "saved_vld in reset", saved_vld_o, 0);
    check("R1", "saved_ptr in reset", saved_ptr_o, 0);
    check("R1", "hold in reset", hold_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: long wait, enable dropped, then done with the line still high
    drive(7'b1111000, 6'd3);
    repeat (4) @(negedge clk);
    check("R4", "frozen during long wait", frozen_o, 0);
    drive(7'b1011000, 6'd3);
    @(negedge clk);
    drive(7'b1011100, 6'd3);
    @(negedge clk);
    check("R8", "frozen after cancelled wait", frozen_o, 0);
    check("R8", "saved_vld after cancelled wait", saved_vld_o, 0);
    drive(7'b0000000, 6'd0);
    @(negedge clk);
    finish_run();
  end
endmodule